// File: doc/BRIEF.md
# Time-Division Slot Flit Injector

This block sits inside a network interface and decides, cycle by cycle, when one channel's words enter a router network. Time is divided into slots of a fixed number of word cycles, and a table of slots repeats without end. A bitmap says which slots belong to the channel. In every owned slot that finds both data and credit, the block sends one flit. If that flit opens a new packet, its first word is a header.

Words arrive from an upstream FIFO through a valid/ready handshake. They pass through a one-register input stage into a local buffer. The credit input carries the number of words the receiver can still take. The output is a registered word stream with a valid flag and a header flag, so a downstream monitor can count the headers in each table period.

A header is forced in two cases: at the first owned slot of every run of adjacent owned slots (runs may wrap from the last slot back to slot 0), and whenever a packet already holds the maximum number of flits. A slot that carries a header loses one payload word.

Top module: `tdm_flit_injector`

## Requirements
- R1: During reset and on the first cycle after it, out_valid and out_hdr are 0 and in_ready is 1. The slot counter restarts at slot 0, word 0 in the first cycle after reset is released.
- R2: A slot lasts FLIT_WORDS=3 cycles and the table has SLOTS=8 slots, so one period is 24 cycles. Slot s of period p starts at cycle 24p+3s, and the index wraps from slot 7 to slot 0.
- R3: An owned slot that starts a flit, when the slot before it (cyclically, including slot 7 to slot 0) sent no flit, begins a new packet with a header. A run that continues across the wrap sends no new header.
- R4: A packet holds at most MAX_FLITS=4 flits. The next owned slot that would add a fifth flit starts a new packet with a header.
- R5: A header-bearing flit has its header in word position 0 and data in positions 1 and 2. Any other flit carries data in all three positions.
- R6: A word accepted at the clock edge ending cycle k can leave in the output register no earlier than the edge ending cycle k+2.
- R7: While credits is 0 no word is sent, data or header, and the owned slot stays idle.
- R8: An owned slot that finds no visible data or zero credit at its word 0 sends nothing. The next flit then starts a new packet with a header. Within a sending slot, a position with no visible data is idle (out_valid 0).
- R9: A new slot bitmap on cfg_slot_map is loaded at reset and at the table wrap (the edge ending slot 7, word 2). A change inside a period has no effect until the next period.
- R10: The outputs are registered: the decision made in cycle c appears during cycle c+1. A header word has out_hdr=1, out_valid=1 and out_data equal to the slot index. A data word has out_hdr=0 and carries the input words in arrival order.
- R11: in_ready is 1 exactly while the buffered words plus the word in the input stage are fewer than DEPTH=16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_slot_map | input | SLOTS | Slot ownership bitmap, bit s for slot s |
| credits | input | CRED_W | Number of words the receiver can still take |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Block can take a word |
| in_data | input | DW | Upstream word |
| out_valid | output | 1 | Output word is present |
| out_hdr | output | 1 | Output word is a packet header |
| out_data | output | DW | Output word |

## Verification
Every output value is due one cycle after the cycle in which the slot counter made its decision. An input word can first take part in a decision two cycles after the edge that accepted it. The bench builds its own expected stream from the slot bitmap, the credit level and the push schedule. It then samples the outputs on the falling edge after each rising edge and compares them cycle by cycle with that stream, so every result is checked in exactly the cycle it is due. Extra checks at chosen cycles cover the wrap-around run, the fifth-flit header, the latency boundary, the idle slot caused by missing data, and the bitmap swap at the period boundary.

// File: rtl/tdm_inj_pkg.sv
package tdm_inj_pkg;
  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_HDR  = 2'd1,
    WK_DATA = 2'd2
  } word_kind_e;
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int SLOTS      = 8,
  parameter int FLIT_WORDS = 3,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int WW = (FLIT_WORDS > 1) ? $clog2(FLIT_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] slot_idx,
  output logic [WW-1:0] word_idx,
  output logic          table_wrap
);
  logic last_word, last_slot;

  assign last_word  = (word_idx == WW'(FLIT_WORDS - 1));
  assign last_slot  = (slot_idx == SW'(SLOTS - 1));
  assign table_wrap = last_word && last_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_idx <= '0;
      slot_idx <= '0;
    end else if (last_word) begin
      word_idx <= '0;
      slot_idx <= last_slot ? '0 : slot_idx + 1'b1;
    end else begin
      word_idx <= word_idx + 1'b1;
    end
  end
endmodule

// File: rtl/tdm_slot_table.sv
module tdm_slot_table #(
  parameter int SLOTS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             table_wrap,
  input  logic [SLOTS-1:0] cfg_map,
  output logic [SLOTS-1:0] live_map
);
  always_ff @(posedge clk) begin
    if (rst || table_wrap) live_map <= cfg_map;
  end
endmodule

// File: rtl/tdm_word_buffer.sv
module tdm_word_buffer #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          pop,
  output logic          nonempty,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] occ
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          stg_v;
  logic [DW-1:0] stg_d;
  logic          accept;

  assign in_ready = ({1'b0, occ} + (CW+1)'(stg_v)) < (CW+1)'(DEPTH);
  assign accept   = in_valid && in_ready;
  assign nonempty = (occ != '0);
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (stg_v) mem[wr_ptr] <= stg_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_v  <= 1'b0;
      stg_d  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      stg_v <= accept;
      if (accept) stg_d <= in_data;
      if (stg_v) wr_ptr <= wr_ptr + 1'b1;
      if (pop)   rd_ptr <= rd_ptr + 1'b1;
      occ <= occ + CW'(stg_v) - CW'(pop);
    end
  end
endmodule

// File: rtl/tdm_flit_injector.sv
module tdm_flit_injector
  import tdm_inj_pkg::*;
#(
  parameter int DW         = 32,
  parameter int SLOTS      = 8,
  parameter int FLIT_WORDS = 3,
  parameter int MAX_FLITS  = 4,
  parameter int DEPTH      = 16,
  parameter int CRED_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOTS-1:0]  cfg_slot_map,
  input  logic [CRED_W-1:0] credits,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  output logic              out_valid,
  output logic              out_hdr,
  output logic [DW-1:0]     out_data
);
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int WW = (FLIT_WORDS > 1) ? $clog2(FLIT_WORDS) : 1;
  localparam int PW = $clog2(MAX_FLITS + 1);
  localparam int CW = $clog2(DEPTH + 1);

  logic [SW-1:0]    slot_idx;
  logic [WW-1:0]    word_idx;
  logic             table_wrap;
  logic [SLOTS-1:0] live_map;
  logic             have_word;
  logic [DW-1:0]    head_word;
  logic [CW-1:0]    buf_occ;
  logic             pop;

  logic             slot_on;
  logic             pkt_open;
  logic [PW-1:0]    flit_cnt;
  logic             slot_go;
  logic             need_hdr;
  logic             cred_ok;
  word_kind_e       kind;

  tdm_slot_timer #(.SLOTS(SLOTS), .FLIT_WORDS(FLIT_WORDS)) u_timer (
    .clk(clk), .rst(rst), .slot_idx(slot_idx), .word_idx(word_idx),
    .table_wrap(table_wrap)
  );

  tdm_slot_table #(.SLOTS(SLOTS)) u_table (
    .clk(clk), .rst(rst), .table_wrap(table_wrap),
    .cfg_map(cfg_slot_map), .live_map(live_map)
  );

  tdm_word_buffer #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .pop(pop), .nonempty(have_word),
    .rd_data(head_word), .occ(buf_occ)
  );

  // Slot-start and per-word decision
  always_comb begin
    cred_ok  = (credits != '0);
    slot_go  = live_map[slot_idx] && have_word && cred_ok;
    need_hdr = !pkt_open || (flit_cnt == PW'(MAX_FLITS));
    kind     = WK_IDLE;
    if (word_idx == '0) begin
      if (slot_go) kind = need_hdr ? WK_HDR : WK_DATA;
    end else if (slot_on && have_word && cred_ok) begin
      kind = WK_DATA;
    end
  end

  assign pop = (kind == WK_DATA);

  // Packet state, updated at word 0 of each slot
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_on  <= 1'b0;
      pkt_open <= 1'b0;
      flit_cnt <= '0;
    end else if (word_idx == '0) begin
      slot_on <= slot_go;
      if (slot_go) begin
        pkt_open <= 1'b1;
        flit_cnt <= need_hdr ? PW'(1) : flit_cnt + 1'b1;
      end else begin
        pkt_open <= 1'b0;
      end
    end
  end

  // Registered output word
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hdr   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= (kind != WK_IDLE);
      out_hdr   <= (kind == WK_HDR);
      case (kind)
        WK_HDR:  out_data <= DW'(slot_idx);
        WK_DATA: out_data <= head_word;
        default: out_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tdm_inj_checker.sv
module tdm_inj_checker #(
  parameter int WW     = 2,
  parameter int CW     = 5,
  parameter int CRED_W = 8,
  parameter int DEPTH  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic              out_hdr,
  input logic [CRED_W-1:0] credits,
  input logic [WW-1:0]     word_idx,
  input logic [CW-1:0]     buf_occ
);
  // R10: a header word is always a valid word
  a_r10_hdr_valid: assert property (@(posedge clk) disable iff (rst)
    out_hdr |-> out_valid);

  // R5: headers only leave from word position 0 of a slot
  a_r5_hdr_at_word0: assert property (@(posedge clk) disable iff (rst)
    out_hdr |-> ($past(word_idx) == '0));

  // R3: two headers never follow each other
  a_r3_no_double_hdr: assert property (@(posedge clk) disable iff (rst)
    out_hdr |=> !out_hdr);

  // R7: zero credit in the decision cycle means nothing is sent
  a_r7_no_send_without_credit: assert property (@(posedge clk) disable iff (rst)
    ($past(credits) == '0) |-> !out_valid);

  // R11: buffer occupancy never exceeds its depth
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
    buf_occ <= CW'(DEPTH));
endmodule

bind tdm_flit_injector tdm_inj_checker #(
  .WW(WW), .CW(CW), .CRED_W(CRED_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_hdr(out_hdr),
  .credits(credits), .word_idx(word_idx), .buf_occ(buf_occ)
);

// File: tb/tb_tdm_flit_injector.sv
module tb_tdm_flit_injector;
  localparam int DW = 32;
  localparam int NC = 72;
  localparam int BASE = 'h100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    cfg_slot_map = '0;
  logic [7:0]    credits = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          out_valid, out_hdr;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic ev [NC];
  logic eh [NC];
  int   ed [NC];
  int   vis [16];
  logic ov [NC];
  logic oh [NC];
  int   od [NC];

  always #2.5 clk = ~clk;

  tdm_flit_injector dut (
    .clk(clk), .rst(rst), .cfg_slot_map(cfg_slot_map), .credits(credits),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_hdr(out_hdr), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected stream from the requirements (R2..R10)
  task automatic build_model(input logic [7:0] t1, input logic [7:0] t2,
                             input int chg, input int cred, input int n);
    int used = 0;
    int fl = 0;
    bit open = 0;
    bit on = 0;
    for (int c = 0; c < NC; c++) begin
      int p = c / 24;
      int s = (c / 3) % 8;
      int w = c % 3;
      logic [7:0] tb_map = (p == 0) ? t1 : ((p * 24 - 1 >= chg) ? t2 : t1);
      bit avail = (used < n) && (vis[used] <= c);
      ev[c] = 0; eh[c] = 0; ed[c] = 0;
      if (w == 0) begin
        if (tb_map[s] && avail && cred != 0) begin
          ev[c] = 1;
          if (!open || fl == 4) begin
            eh[c] = 1; ed[c] = s; fl = 1;
          end else begin
            ed[c] = BASE + used; used++; fl++;
          end
          open = 1; on = 1;
        end else begin
          open = 0; on = 0;
        end
      end else if (on && avail && cred != 0) begin
        ev[c] = 1; ed[c] = BASE + used; used++;
      end
    end
  endtask

  // Runs one scenario: n1 words from cycle s1, remaining from s2
  task automatic run_case(input string req, input logic [7:0] t1, input logic [7:0] t2,
                          input int chg, input int cred, input int n, input int n1,
                          input int s1, input int s2);
    int pushed = 0;
    for (int j = 0; j < n; j++)
      vis[j] = ((j < n1) ? (s1 + j) : (s2 + j - n1)) + 2;
    build_model(t1, t2, chg, cred, n);
    rst = 1'b1; in_valid = 1'b0;
    cfg_slot_map = t1; credits = 8'(cred);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NC; i++) begin
      if (i == chg) cfg_slot_map = t2;
      in_valid = 1'b0;
      if (pushed < n && vis[pushed] - 2 == i) begin
        chk(in_ready == 1'b1, "R11 ready while pushing", int'(in_ready), 1);
        in_valid = 1'b1;
        in_data  = BASE + pushed;
        pushed++;
      end
      @(negedge clk);
      ov[i] = out_valid; oh[i] = out_hdr; od[i] = out_data;
      chk(out_valid == ev[i], {req, " valid"}, int'(out_valid), int'(ev[i]));
      chk(out_hdr == eh[i], {req, " hdr"}, int'(out_hdr), int'(eh[i]));
      if (ev[i]) chk(out_data == DW'(ed[i]), {req, " data"}, int'(out_data), ed[i]);
    end
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 0, "R1 reset valid", int'(out_valid), 0);
    chk(out_hdr == 0, "R1 reset hdr", int'(out_hdr), 0);
    chk(in_ready == 1, "R1 reset ready", int'(in_ready), 1);
  endtask

  task automatic t_long_group;
    int nh = 0;
    run_case("R5 group", 8'h7C, 8'h7C, NC, 5, 16, 16, 0, 0);
    for (int i = 0; i < 48; i++) if (oh[i]) nh++;
    chk(nh == 3, "R4 headers in long group", nh, 3);
    chk(oh[6] == 1, "R3 first slot of run", int'(oh[6]), 1);
  endtask

  task automatic t_wrap_run;
    run_case("R3 wrap", 8'h83, 8'h83, NC, 5, 16, 16, 0, 0);
    chk(ov[24] == 1 && oh[24] == 0, "R3 no header across wrap", int'(oh[24]), 0);
    chk(oh[21] == 1, "R3 header after gap", int'(oh[21]), 1);
  endtask

  task automatic t_max_packet;
    run_case("R4 full table", 8'hFF, 8'hFF, NC, 5, 16, 16, 0, 0);
    chk(oh[15] == 1, "R4 fifth flit gets header", int'(oh[15]), 1);
    chk(oh[12] == 0 && ov[12] == 1, "R2 slot4 continues packet", int'(oh[12]), 0);
  endtask

  task automatic t_latency;
    run_case("R6 latency", 8'hFF, 8'hFF, NC, 5, 2, 1, 0, 5);
    chk(ov[6] == 0, "R6 word not visible yet", int'(ov[6]), 0);
    chk(oh[9] == 1, "R8 new packet after idle slot", int'(oh[9]), 1);
  endtask

  task automatic t_no_credit;
    int nv = 0;
    run_case("R7 zero credit", 8'hFF, 8'hFF, NC, 0, 16, 16, 0, 0);
    for (int i = 0; i < NC; i++) if (ov[i]) nv++;
    chk(nv == 0, "R7 nothing sent", nv, 0);
  endtask

  task automatic t_runout;
    run_case("R8 runout", 8'h3C, 8'h3C, NC, 5, 8, 4, 0, 30);
    chk(ov[11] == 0, "R8 empty position idle", int'(ov[11]), 0);
    chk(ov[30] == 0, "R8 owned slot without data idle", int'(ov[30]), 0);
    chk(oh[33] == 1, "R8 header after idle slot", int'(oh[33]), 1);
  endtask

  task automatic t_cfg_swap;
    run_case("R9 swap", 8'h01, 8'h10, 10, 5, 16, 16, 0, 0);
    chk(ov[12] == 0, "R9 change waits for wrap", int'(ov[12]), 0);
    chk(oh[36] == 1 && od[36] == 4, "R9 new map after wrap", int'(oh[36]), 1);
  endtask

  initial begin
    t_reset();
    t_long_group();
    t_wrap_run();
    t_max_packet();
    t_latency();
    t_no_credit();
    t_runout();
    t_cfg_swap();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule